// File: doc/BRIEF.md
# Two-Party Claim-Line Bus Arbiter

This block wins exclusive use of a shared bus for a local bus master, using two single-bit sideband wires. The local side drives its own claim wire and watches the claim wire of the other party. When the local master raises its request, the block raises its claim and waits a settle interval. It then polls the other party's wire for up to one retry interval and grants the bus as soon as that wire is seen low. If the wire stays high for the whole retry interval, the block drops its claim and backs off for one retry interval. It then tries again.

An overall timer starts when a request is accepted. A new attempt begins only while that timer is below a give-up limit. Past the limit, the block stops, leaves its claim low and raises a sticky wedged flag. The grant stays high until the master pulses release. The block then drops its claim and waits one settle interval before it can take a new request. The other party's wire passes through a two-flop synchronizer. Because the protocol is symmetric, the same block can serve as the other party with the wires swapped. All intervals are parameters in clock cycles. Their defaults are derived from a clock-frequency parameter: 10 us settle, 3 ms retry and 50 ms limit.

Top module: `claim_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, our_claim_o, grant_o and wedged_o are all low.
- R2: The edge that samples req_i high in idle is the accept edge, edge 0. At edge 0 our_claim_o goes high. If the other party's wire is low, grant_o goes high at edge SETTLE_CYC+1.
- R3: The other party's wire is seen through two flops. After it falls following edge D, the block sees it low at edges from D+3 onward. During an attempt the block polls at the RETRY_CYC edges after the settle interval. It grants at the first polled edge where the wire is seen low.
- R4: Suppose the wire is seen high at all RETRY_CYC polled edges of an attempt. our_claim_o then falls at the last polled edge and stays low for RETRY_CYC cycles. It rises again at edge SETTLE_CYC+2*RETRY_CYC of that attempt, which starts a new attempt with period SETTLE_CYC+2*RETRY_CYC.
- R5: At the end of each back-off, a new attempt starts only if fewer than LIMIT_CYC cycles have passed since the accept edge. Otherwise the block goes idle with wedged_o high and our_claim_o low.
- R6: wedged_o stays high until the next accepted request, which clears it at the accept edge.
- R7: grant_o stays high until rel_i is sampled high. At that edge grant_o and our_claim_o both fall.
- R8: req_i is ignored while the grant is held and for SETTLE_CYC cycles after the release edge. A request held high through that time is accepted at the edge after the settle interval ends.
- R9: Asserting the asynchronous reset in any state, including mid-grant, at once drives our_claim_o and grant_o low and returns the block to idle.
- R10: grant_o is never high unless our_claim_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Local master requests the bus (level) |
| rel_i | input | 1 | Local master gives the bus back |
| their_claim_i | input | 1 | Other party's claim wire, asynchronous |
| our_claim_o | output | 1 | Local claim wire toward the other party |
| grant_o | output | 1 | Bus is held by the local side |
| wedged_o | output | 1 | Sticky give-up flag |

## Verification
The bench counts edges from the accept edge. The claim rises at edge 0, and an uncontended grant arrives at edge SETTLE_CYC+1. A wire drop after edge D is seen from edge D+3, so a contended grant arrives at the later of those two edges, provided it falls inside a polling window. Back-off, retry and give-up edges follow from the attempt period SETTLE_CYC+2*RETRY_CYC. Release takes effect at the edge that samples rel_i. Each output is sampled at the falling edge after the edge where it is due to change, and the remote wire is driven at falling edges so its synchronizer delay is exact.

// File: rtl/claim_arbiter.sv
module claim_arbiter #(
  parameter int CLK_HZ     = 250_000_000,
  parameter int SETTLE_CYC = CLK_HZ / 100_000,
  parameter int RETRY_CYC  = (CLK_HZ / 1000) * 3,
  parameter int LIMIT_CYC  = CLK_HZ / 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic rel_i,
  input  logic their_claim_i,
  output logic our_claim_o,
  output logic grant_o,
  output logic wedged_o
);
  localparam int MAXP = (RETRY_CYC > SETTLE_CYC) ? RETRY_CYC : SETTLE_CYC;
  localparam int CW   = $clog2(MAXP) + 1;
  localparam int TW   = $clog2(LIMIT_CYC + 1) + 1;
  localparam logic [CW-1:0] SET_END = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] RET_END = CW'(RETRY_CYC - 1);
  localparam logic [TW-1:0] LIM     = TW'(LIMIT_CYC);

  typedef enum logic [2:0] {
    S_IDLE, S_SETTLE, S_POLL, S_BACK, S_HELD, S_REL
  } st_t;

  st_t            st;
  logic [1:0]     sync;
  logic [CW-1:0]  cnt;
  logic [TW-1:0]  tot;
  logic           busy;

  assign busy        = (st == S_SETTLE) || (st == S_POLL) || (st == S_BACK);
  assign our_claim_o = (st == S_SETTLE) || (st == S_POLL) || (st == S_HELD);
  assign grant_o     = (st == S_HELD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync     <= '0;
      st       <= S_IDLE;
      cnt      <= '0;
      tot      <= '0;
      wedged_o <= 1'b0;
    end else begin
      sync <= {sync[0], their_claim_i};
      cnt  <= cnt + 1'b1;
      if (busy && tot < LIM) tot <= tot + 1'b1;
      case (st)
        S_IDLE:
          if (req_i) begin
            st       <= S_SETTLE;
            cnt      <= '0;
            tot      <= TW'(1);
            wedged_o <= 1'b0;
          end
        S_SETTLE:
          if (cnt == SET_END) begin
            st  <= S_POLL;
            cnt <= '0;
          end
        S_POLL:
          if (!sync[1]) st <= S_HELD;
          else if (cnt == RET_END) begin
            st  <= S_BACK;
            cnt <= '0;
          end
        S_BACK:
          if (cnt == RET_END) begin
            cnt <= '0;
            if (tot < LIM) st <= S_SETTLE;
            else begin
              st       <= S_IDLE;
              wedged_o <= 1'b1;
            end
          end
        S_HELD:
          if (rel_i) begin
            st  <= S_REL;
            cnt <= '0;
          end
        S_REL:
          if (cnt == SET_END) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/claim_arbiter_chk.sv
module claim_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic req_i,
  input logic rel_i,
  input logic their_claim_i,
  input logic our_claim_o,
  input logic grant_o,
  input logic wedged_o
);
  p_grant_claim_r10: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> our_claim_o);
  p_wedge_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wedged_o |-> (!our_claim_o && !grant_o));
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o && rel_i) |=> (!grant_o && !our_claim_o));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o && !rel_i) |=> grant_o);
  p_free_seen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_o) |-> !$past(their_claim_i, 3));
  p_claim_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_o) |-> $past(our_claim_o));
  p_wedge_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wedged_o && !req_i) |=> wedged_o);
endmodule

bind claim_arbiter claim_arbiter_chk u_chk (.*);

// File: tb/sim_claim_arbiter.sv
module sim_claim_arbiter;
  localparam int S = 4;
  localparam int R = 10;
  localparam int L = 60;
  localparam int NV = 9;
  localparam int VD [NV] = '{-5, 2, 5, 11, 12, 30, 40, 60, 999};
  localparam int VG [NV] = '{ 5, 5, 8, 14, 29, 33, 53,  0,   0};
  localparam int VW [NV] = '{ 0, 0, 0,  0,  0,  0,  0, 72,  72};

  logic clk = 0, rst_n = 0, req = 0, rel = 0, tc = 0;
  logic claim, grant, wedged;
  int errs = 0, checks = 0;

  always #2 clk = ~clk;

  claim_arbiter #(.SETTLE_CYC(S), .RETRY_CYC(R), .LIMIT_CYC(L)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .rel_i(rel), .their_claim_i(tc),
    .our_claim_o(claim), .grant_o(grant), .wedged_o(wedged));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    #400000;
    errs++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({claim, grant, wedged} == 3'b000, "R1 during reset", {claim, grant, wedged}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk({claim, grant, wedged} == 3'b000, "R1 after reset", {claim, grant, wedged}, 0);

    for (int v = 0; v < NV; v++) begin
      int gotg, gotw;
      gotg = 0; gotw = 0;
      tc = (VD[v] < 0) ? 1'b0 : 1'b1;
      repeat (4) @(negedge clk);
      req = 1;
      @(negedge clk);
      req = 0;
      if (VD[v] == 0) tc = 0;
      chk(claim == 1, "R2 claim at accept", claim, 1);
      for (int e = 1; e <= 90; e++) begin
        @(negedge clk);
        if (e == VD[v]) tc = 0;
        if (grant && gotg == 0) begin
          gotg = e;
          chk(claim == 1, "R10 claim with grant", claim, 1);
        end
        if (wedged && gotw == 0) gotw = e;
        if (VG[v] > S + R || VG[v] == 0) begin
          if (e == S + R + 1) chk(claim == 0, "R4 backoff claim low", claim, 0);
          if (e == S + 2*R - 1) chk(claim == 0, "R4 backoff end low", claim, 0);
          if (e == S + 2*R) chk(claim == 1, "R4 retry reassert", claim, 1);
        end
      end
      if (VG[v] <= S + 1 && VG[v] != 0)
        chk(gotg == VG[v], "R2 uncontended grant edge", gotg, VG[v]);
      else
        chk(gotg == VG[v], "R3 polled grant edge", gotg, VG[v]);
      chk(gotw == VW[v], "R5 wedge edge", gotw, VW[v]);
      if (VW[v] != 0) begin
        chk(claim == 0, "R5 claim low when wedged", claim, 0);
        chk(wedged == 1, "R6 wedged sticky", wedged, 1);
      end else begin
        chk(grant == 1, "R7 grant held", grant, 1);
        rel = 1;
        @(negedge clk);
        rel = 0;
        chk({grant, claim} == 2'b00, "R7 release drops", {grant, claim}, 0);
        repeat (S + 2) @(negedge clk);
      end
    end

    tc = 0;
    req = 1;
    @(negedge clk);
    req = 0;
    chk(wedged == 0, "R6 cleared by request", wedged, 0);
    repeat (S + 1) @(negedge clk);
    chk(grant == 1, "R2 grant after clear", grant, 1);

    req = 1;
    repeat (3) @(negedge clk);
    chk(grant == 1 && claim == 1, "R8 request while held", {grant, claim}, 3);
    rel = 1;
    @(negedge clk);
    rel = 0;
    chk(claim == 0, "R7 release with request high", claim, 0);
    for (int k = 1; k <= S; k++) begin
      @(negedge clk);
      chk(claim == 0, "R8 ignored in release settle", claim, 0);
    end
    @(negedge clk);
    chk(claim == 1, "R8 accepted after settle", claim, 1);
    req = 0;
    repeat (S + 1) @(negedge clk);
    chk(grant == 1, "R2 regrant", grant, 1);

    rst_n = 0;
    #1;
    chk({claim, grant, wedged} == 3'b000, "R9 reset mid grant", {claim, grant, wedged}, 0);
    @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk({claim, grant} == 2'b00, "R9 idle after reset", {claim, grant}, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule